// File: doc/BRIEF.md
# PCI Type 0 Configuration Header Registers

This block holds the 64-byte Type 0 configuration header of a simple PCI target. The bus front end decodes the command phase and registers the address. It then hands this block the low address byte, the data phase, the active-low C/BE# lanes, a configuration-write or configuration-read qualifier, and the IRDY#/TRDY# handshake. The command codes are 1011 for a configuration write and 1010 for a configuration read. The block does not cover the bus state machine, parity, DEVSEL# timing or the memory data path.

Three places in the header accept writes: the Command half of dword 04h, one 32-bit memory BAR at 10h, and the Interrupt Line byte at 3Ch. Each write is merged byte by byte under the active-low enables. All other header fields are constants set by parameters. The identity fields at 00h, 08h, 0Ch and 2Ch come from parameters. The BAR decodes a naturally aligned region of 2^BAR_SIZE_LOG2 bytes, 4 KB by default. Its low bits always read zero, so the usual all-ones sizing probe works. The Command bits, the BAR and the Interrupt Line drive outputs for the rest of the design.

A read returns the addressed dword combinationally in the same cycle. An unimplemented offset reads as zero.

Top module: `pci_cfg_header`

## Requirements
- R1: While `rst_n` is low, and after it is released, `cmd_o`, `bar_o` and `int_line_o` are zero until the first committed write. Reads of 04h and 10h then return 0, and a read of 3Ch returns only the constant bytes.
- R2: A write commits at a rising clock edge only if `cfg_wr`=1, `irdy_n`=0 and `trdy_n`=0 all hold in that cycle. If any one of the three fails, no register changes.
- R3: A committed write changes a register only when `cfg_addr` equals exactly 04h, 10h or 3Ch. Any other byte address, including 05h or 11h, leaves every register unchanged.
- R4: Byte lane i holds data bits 8i+7..8i. It is written only when `cfg_be_n[i]`=0. Lanes whose enable is 1 keep their old contents.
- R5: Dword 04h reads as {16'h0000 status, command}. All 16 command bits are writable through lanes 0 and 1. Writes to lanes 2 and 3 have no effect.
- R6: Dword 10h reads as the BAR. Bits 31..BAR_SIZE_LOG2 are writable. Bits BAR_SIZE_LOG2-1..0 always read 0, which makes bit 0 the memory-space indicator. Writing FFFFFFFFh with all lanes enabled reads back FFFFF000h at the default size.
- R7: Dword 3Ch reads as {MAX_LAT[31:24], MIN_GNT[23:16], 01h interrupt pin [15:8], interrupt line [7:0]}. Only the interrupt line byte is writable.
- R8: Dword 00h reads {DEVICE_ID, VENDOR_ID}, 08h reads {CLASS_CODE, REV_ID}, 0Ch reads {8'h00, HDR_TYPE, 8'h00, 8'h00}, and 2Ch reads {SUBSYS_ID, SUBSYS_VID}. Writes to these dwords are ignored.
- R9: Every other dword offset from 14h to FCh reads as zero. `cfg_rdata` is zero whenever `cfg_rd` is 0.
- R10: `cmd_o`, `bar_o` and `int_line_o` take a committed value on the clock edge at which the write commits.
- R11: A read selects the dword with `cfg_addr[7:2]` and ignores `cfg_addr[1:0]`. The data appears combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 8 | Registered address bits 7:0 |
| cfg_wdata | input | 32 | Write data of the data phase |
| cfg_be_n | input | 4 | Active-low byte enables |
| cfg_wr | input | 1 | Configuration-write qualifier |
| cfg_rd | input | 1 | Configuration-read qualifier |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| cfg_rdata | output | 32 | Read data of the addressed dword |
| cmd_o | output | 16 | Command register |
| bar_o | output | 32 | Memory BAR, low bits zero |
| int_line_o | output | 8 | Interrupt Line register |

## Verification
A decode or merge fault corrupts a register. That corruption appears on `cmd_o`, `bar_o` or `int_line_o` at the edge that commits the write. It also shows in the same cycle as a wrong dword in any later read of that offset. A stray strobe from the wrong offset or a failed handshake therefore shows up in the very next comparison. A read-mux fault affects only `cfg_rdata`, and it is visible combinationally for the offset that is wrong. Sweeping every byte address against every enable pattern, and reading back the whole header after each write, catches both kinds of fault within one write of their cause.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;

  localparam int unsigned DWORD_BYTES = 4;

  // Exact byte addresses that accept writes
  localparam logic [7:0] OFS_CMD  = 8'h04;
  localparam logic [7:0] OFS_BAR  = 8'h10;
  localparam logic [7:0] OFS_INTR = 8'h3C;

  // Dword indices used by the read mux (address bits 7:2)
  localparam logic [5:0] DW_ID    = 6'h00;
  localparam logic [5:0] DW_CMD   = 6'h01;
  localparam logic [5:0] DW_CLASS = 6'h02;
  localparam logic [5:0] DW_MISC  = 6'h03;
  localparam logic [5:0] DW_BAR   = 6'h04;
  localparam logic [5:0] DW_SUBS  = 6'h0B;
  localparam logic [5:0] DW_INTR  = 6'h0F;

  localparam logic [7:0] INT_PIN_A = 8'h01;

  typedef struct packed {
    logic cmd;
    logic bar;
    logic intr;
  } wr_sel_t;

endpackage

// File: rtl/pci_cfg_rst_sync.sv
module pci_cfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pci_cfg_wr_decode.sv
module pci_cfg_wr_decode
  import pci_cfg_pkg::*;
(
  input  logic [7:0] cfg_addr,
  input  logic       cfg_wr,
  input  logic       irdy_n,
  input  logic       trdy_n,
  output wr_sel_t    sel
);

  logic commit;

  always_comb begin
    commit   = cfg_wr & ~irdy_n & ~trdy_n;
    sel.cmd  = commit & (cfg_addr == OFS_CMD);
    sel.bar  = commit & (cfg_addr == OFS_BAR);
    sel.intr = commit & (cfg_addr == OFS_INTR);
  end

endmodule

// File: rtl/pci_cfg_byte_merge.sv
module pci_cfg_byte_merge #(
  parameter int unsigned     LANES = 4,
  parameter logic [8*LANES-1:0] WMASK = '1
) (
  input  logic [8*LANES-1:0] old_val,
  input  logic [8*LANES-1:0] wdata,
  input  logic [LANES-1:0]   be_n,
  output logic [8*LANES-1:0] new_val
);

  localparam int unsigned W = 8 * LANES;

  logic [W-1:0] lane_mask;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_mask[8*i +: 8] = {8{~be_n[i]}};
  end

  always_comb begin
    new_val = (old_val & ~(lane_mask & WMASK)) | (wdata & lane_mask & WMASK);
  end

endmodule

// File: rtl/pci_cfg_regs.sv
module pci_cfg_regs
  import pci_cfg_pkg::*;
#(
  parameter int unsigned BAR_SIZE_LOG2 = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  wr_sel_t     sel,
  input  logic [31:0] wdata,
  input  logic [3:0]  be_n,
  output logic [15:0] cmd_q,
  output logic [31:0] bar_q,
  output logic [7:0]  intl_q
);

  localparam int unsigned BAR_W = 32 - BAR_SIZE_LOG2;
  localparam logic [31:0] BAR_WMASK = {{BAR_W{1'b1}}, {BAR_SIZE_LOG2{1'b0}}};

  logic [15:0]      cmd_r;
  logic [BAR_W-1:0] bar_hi_r;
  logic [7:0]       intl_r;

  logic [31:0] cmd_m, bar_m, intl_m;
  logic [15:0]      cmd_d;
  logic [BAR_W-1:0] bar_hi_d;
  logic [7:0]       intl_d;

  pci_cfg_byte_merge #(.LANES(4), .WMASK(32'h0000_FFFF)) u_merge_cmd (
    .old_val ({16'h0000, cmd_r}),
    .wdata   (wdata),
    .be_n    (be_n),
    .new_val (cmd_m)
  );

  pci_cfg_byte_merge #(.LANES(4), .WMASK(BAR_WMASK)) u_merge_bar (
    .old_val ({bar_hi_r, {BAR_SIZE_LOG2{1'b0}}}),
    .wdata   (wdata),
    .be_n    (be_n),
    .new_val (bar_m)
  );

  pci_cfg_byte_merge #(.LANES(4), .WMASK(32'h0000_00FF)) u_merge_intl (
    .old_val ({24'h000000, intl_r}),
    .wdata   (wdata),
    .be_n    (be_n),
    .new_val (intl_m)
  );

  // Next-state
  always_comb begin
    cmd_d    = cmd_m[15:0];
    bar_hi_d = bar_m[31:BAR_SIZE_LOG2];
    intl_d   = intl_m[7:0];
  end

  // Registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_r    <= '0;
      bar_hi_r <= '0;
      intl_r   <= '0;
    end else begin
      if (sel.cmd)  cmd_r    <= cmd_d;
      if (sel.bar)  bar_hi_r <= bar_hi_d;
      if (sel.intr) intl_r   <= intl_d;
    end
  end

  assign cmd_q  = cmd_r;
  assign bar_q  = {bar_hi_r, {BAR_SIZE_LOG2{1'b0}}};
  assign intl_q = intl_r;

endmodule

// File: rtl/pci_cfg_rd_mux.sv
module pci_cfg_rd_mux
  import pci_cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1AB7,
  parameter logic [15:0] DEVICE_ID  = 16'h7E21,
  parameter logic [23:0] CLASS_CODE = 24'hFF0000,
  parameter logic [7:0]  REV_ID     = 8'h03,
  parameter logic [7:0]  HDR_TYPE   = 8'h00,
  parameter logic [15:0] SUBSYS_VID = 16'h1AB7,
  parameter logic [15:0] SUBSYS_ID  = 16'h0042,
  parameter logic [7:0]  MIN_GNT    = 8'h04,
  parameter logic [7:0]  MAX_LAT    = 8'h10
) (
  input  logic [5:0]  dw_idx,
  input  logic        cfg_rd,
  input  logic [15:0] cmd_q,
  input  logic [31:0] bar_q,
  input  logic [7:0]  intl_q,
  output logic [31:0] rdata
);

  logic [31:0] sel_data;

  always_comb begin
    unique case (dw_idx)
      DW_ID:    sel_data = {DEVICE_ID, VENDOR_ID};
      DW_CMD:   sel_data = {16'h0000, cmd_q};
      DW_CLASS: sel_data = {CLASS_CODE, REV_ID};
      DW_MISC:  sel_data = {8'h00, HDR_TYPE, 8'h00, 8'h00};
      DW_BAR:   sel_data = bar_q;
      DW_SUBS:  sel_data = {SUBSYS_ID, SUBSYS_VID};
      DW_INTR:  sel_data = {MAX_LAT, MIN_GNT, INT_PIN_A, intl_q};
      default:  sel_data = 32'h0000_0000;
    endcase
    rdata = cfg_rd ? sel_data : 32'h0000_0000;
  end

endmodule

// File: rtl/pci_cfg_header.sv
module pci_cfg_header
  import pci_cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'h1AB7,
  parameter logic [15:0] DEVICE_ID     = 16'h7E21,
  parameter logic [23:0] CLASS_CODE    = 24'hFF0000,
  parameter logic [7:0]  REV_ID        = 8'h03,
  parameter logic [7:0]  HDR_TYPE      = 8'h00,
  parameter logic [15:0] SUBSYS_VID    = 16'h1AB7,
  parameter logic [15:0] SUBSYS_ID     = 16'h0042,
  parameter logic [7:0]  MIN_GNT       = 8'h04,
  parameter logic [7:0]  MAX_LAT       = 8'h10,
  parameter int unsigned BAR_SIZE_LOG2 = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic [3:0]  cfg_be_n,
  input  logic        cfg_wr,
  input  logic        cfg_rd,
  input  logic        irdy_n,
  input  logic        trdy_n,
  output logic [31:0] cfg_rdata,
  output logic [15:0] cmd_o,
  output logic [31:0] bar_o,
  output logic [7:0]  int_line_o
);

  logic    rst_sync_n;
  wr_sel_t sel;

  pci_cfg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pci_cfg_wr_decode u_dec (
    .cfg_addr (cfg_addr),
    .cfg_wr   (cfg_wr),
    .irdy_n   (irdy_n),
    .trdy_n   (trdy_n),
    .sel      (sel)
  );

  pci_cfg_regs #(.BAR_SIZE_LOG2(BAR_SIZE_LOG2)) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .sel    (sel),
    .wdata  (cfg_wdata),
    .be_n   (cfg_be_n),
    .cmd_q  (cmd_o),
    .bar_q  (bar_o),
    .intl_q (int_line_o)
  );

  pci_cfg_rd_mux #(
    .VENDOR_ID  (VENDOR_ID),
    .DEVICE_ID  (DEVICE_ID),
    .CLASS_CODE (CLASS_CODE),
    .REV_ID     (REV_ID),
    .HDR_TYPE   (HDR_TYPE),
    .SUBSYS_VID (SUBSYS_VID),
    .SUBSYS_ID  (SUBSYS_ID),
    .MIN_GNT    (MIN_GNT),
    .MAX_LAT    (MAX_LAT)
  ) u_rd (
    .dw_idx (cfg_addr[7:2]),
    .cfg_rd (cfg_rd),
    .cmd_q  (cmd_o),
    .bar_q  (bar_o),
    .intl_q (int_line_o),
    .rdata  (cfg_rdata)
  );

endmodule

// File: rtl/pci_cfg_header_chk.sv
module pci_cfg_header_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  cfg_addr,
  input logic [3:0]  cfg_be_n,
  input logic        cfg_wr,
  input logic        cfg_rd,
  input logic        irdy_n,
  input logic        trdy_n,
  input logic [31:0] cfg_rdata,
  input logic [15:0] cmd_o,
  input logic [31:0] bar_o,
  input logic [7:0]  int_line_o
);

  // R2
  a_r2_no_commit_without_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && !irdy_n && !trdy_n) |=> ($stable(cmd_o) && $stable(bar_o) && $stable(int_line_o)));

  // R3
  a_r3_cmd_offset_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr != 8'h04) |=> $stable(cmd_o));
  a_r3_bar_offset_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr != 8'h10) |=> $stable(bar_o));
  a_r3_intl_offset_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr != 8'h3C) |=> $stable(int_line_o));

  // R4
  a_r4_lane0_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_be_n[0] |=> ($stable(cmd_o[7:0]) && $stable(int_line_o)));
  a_r4_lane1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_be_n[1] |=> $stable(cmd_o[15:8]));
  a_r4_lane3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_be_n[3] |=> $stable(bar_o[31:24]));

  // R5
  a_r5_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_addr[7:2] == 6'h01) |-> (cfg_rdata[31:16] == 16'h0000));

  // R6
  a_r6_bar_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_addr[7:2] == 6'h04) |-> (cfg_rdata[11:0] == 12'h000));

  // R7
  a_r7_int_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_addr[7:2] == 6'h0F) |-> (cfg_rdata[15:8] == 8'h01));

  // R9
  a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd |-> (cfg_rdata == 32'h0000_0000));

endmodule

bind pci_cfg_header pci_cfg_header_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_addr   (cfg_addr),
  .cfg_be_n   (cfg_be_n),
  .cfg_wr     (cfg_wr),
  .cfg_rd     (cfg_rd),
  .irdy_n     (irdy_n),
  .trdy_n     (trdy_n),
  .cfg_rdata  (cfg_rdata),
  .cmd_o      (cmd_o),
  .bar_o      (bar_o),
  .int_line_o (int_line_o)
);

// File: tb/pci_cfg_header_test.sv
module pci_cfg_header_test;

  localparam int PERIOD = 200;

  localparam logic [15:0] T_VID  = 16'h1AB7;
  localparam logic [15:0] T_DID  = 16'h7E21;
  localparam logic [23:0] T_CC   = 24'hFF0000;
  localparam logic [7:0]  T_REV  = 8'h03;
  localparam logic [7:0]  T_HDR  = 8'h00;
  localparam logic [15:0] T_SVID = 16'h1AB7;
  localparam logic [15:0] T_SID  = 16'h0042;
  localparam logic [7:0]  T_MING = 8'h04;
  localparam logic [7:0]  T_MAXL = 8'h10;
  localparam logic [31:0] T_BARM = 32'hFFFF_F000;

  logic        clk;
  logic        rst_n;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [3:0]  cfg_be_n;
  logic        cfg_wr, cfg_rd, irdy_n, trdy_n;
  logic [31:0] cfg_rdata;
  logic [15:0] cmd_o;
  logic [31:0] bar_o;
  logic [7:0]  int_line_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [15:0] e_cmd;
  logic [31:0] e_bar;
  logic [7:0]  e_intl;

  pci_cfg_header #(
    .VENDOR_ID(T_VID), .DEVICE_ID(T_DID), .CLASS_CODE(T_CC), .REV_ID(T_REV),
    .HDR_TYPE(T_HDR), .SUBSYS_VID(T_SVID), .SUBSYS_ID(T_SID),
    .MIN_GNT(T_MING), .MAX_LAT(T_MAXL), .BAR_SIZE_LOG2(12)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_be_n(cfg_be_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .cfg_rdata(cfg_rdata), .cmd_o(cmd_o), .bar_o(bar_o),
    .int_line_o(int_line_o)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [5:0] dw);
    case (dw)
      6'h00:   return {T_DID, T_VID};
      6'h01:   return {16'h0000, e_cmd};
      6'h02:   return {T_CC, T_REV};
      6'h03:   return {8'h00, T_HDR, 16'h0000};
      6'h04:   return e_bar;
      6'h0B:   return {T_SID, T_SVID};
      6'h0F:   return {T_MAXL, T_MING, 8'h01, e_intl};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [5:0] dw);
    case (dw)
      6'h01:                  return "R5";
      6'h04:                  return "R6";
      6'h0F:                  return "R7";
      6'h00, 6'h02, 6'h03, 6'h0B: return "R8";
      default:                return "R9";
    endcase
  endfunction

  // Model of a committed write, from R3..R7
  task automatic model_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    for (int i = 0; i < 4; i++) begin
      if (!be[i]) begin
        if (a == 8'h04 && i < 2) e_cmd[8*i +: 8] = d[8*i +: 8];
        if (a == 8'h10)          e_bar[8*i +: 8] = d[8*i +: 8];
        if (a == 8'h3C && i == 0) e_intl = d[7:0];
      end
    end
    e_bar &= T_BARM;
  endtask

  // Reads every dword; R11: low address bits vary and must not matter
  task automatic read_all();
    cfg_rd = 1'b1;
    for (int dw = 0; dw < 64; dw++) begin
      cfg_addr = {dw[5:0], dw[1:0] ^ 2'b11};
      #1;
      check(req_of(dw[5:0]), cfg_rdata, exp_read(dw[5:0]));
    end
    cfg_rd = 1'b0;
    #1;
    check("R9", cfg_rdata, 32'h0);
  endtask

  task automatic check_outs(input string req);
    check(req, {16'h0, cmd_o}, {16'h0, e_cmd});
    check(req, bar_o, e_bar);
    check(req, {24'h0, int_line_o}, {24'h0, e_intl});
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d,
                           input logic wr, input logic ir, input logic tr);
    @(negedge clk);
    cfg_addr = a; cfg_be_n = be; cfg_wdata = d;
    cfg_wr = wr; irdy_n = ir; trdy_n = tr;
    @(negedge clk);
    cfg_wr = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1;
    if (wr && !ir && !tr) model_write(a, be, d);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    e_cmd = '0; e_bar = '0; e_intl = '0;
    check_outs("R1");
    read_all();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_outs("R1");
  endtask

  initial begin
    logic [31:0] pat;
    rst_n = 1'b0; cfg_addr = '0; cfg_wdata = '0; cfg_be_n = 4'hF;
    cfg_wr = 1'b0; cfg_rd = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1;
    pat = 32'h0F1E_2D3C;
    do_reset();

    // R2: every handshake combination at each writable offset
    for (int t = 0; t < 3; t++) begin
      for (int c = 0; c < 8; c++) begin
        pat = pat * 32'h9E37_79B1 + 32'h1357_9BDF;
        bus_write(t == 0 ? 8'h04 : (t == 1 ? 8'h10 : 8'h3C), 4'h0, pat, c[2], c[1], c[0]);
        check_outs("R2");
      end
    end

    // R6: sizing probe
    bus_write(8'h10, 4'h0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0);
    check("R6", bar_o, 32'hFFFF_F000);

    // R3/R4/R10: every byte address against every enable pattern
    for (int a = 0; a < 256; a++) begin
      for (int be = 0; be < 16; be++) begin
        pat = pat * 32'h9E37_79B1 + 32'h1357_9BDF;
        bus_write(a[7:0], be[3:0], pat, 1'b1, 1'b0, 1'b0);
        check_outs((a == 8'h04 || a == 8'h10 || a == 8'h3C) ? "R4 R10" : "R3");
        if ((be % 5) == 0) read_all();
      end
    end

    // R1: reset again after registers hold data
    do_reset();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule